// File: doc/BRIEF.md
# Two-Line Prioritized Interrupt Vector Unit

This block gathers the completion ("finished") and pause ("suspended") events of sixteen transfer groups, together with four error events, into two interrupt lines. Every event latches into a flag of its own. Software decides, per event, whether the flag takes part in interrupts and which of the two lines it drives. Each line has a vector, a small number that names the most urgent enabled source on that line, plus a type bit that says whether a group source is a suspend or a finish.

Software services a line by reading its vector. That read clears the group flag the vector names, and the vector then moves to the next pending source. Error flags share one vector code per line. They are cleared only by writing ones to them, so an error vector stays visible until software clears it explicitly. The bus decode that produces the read and write strobes is outside the block. So are the event sources.

Top module: `irq_vec_unit`

## Requirements
- R1: After a synchronous active-low reset, all flags are zero, both lines are low and both vectors read 0.
- R2: An event pulse sets its flag on the next clock edge, whether or not the event is enabled and whatever line it is mapped to.
- R3: When the flag write strobe is high, every flag whose mask bit is one is cleared on the next edge. Flags whose mask bit is zero keep their value.
- R4: A line is high exactly while at least one flag that is enabled and mapped to that line is set.
- R5: Vector code 0 means nothing is pending on the line. Code g+1 names group g. Code 17 names the shared error source. The type bit is 1 for a group suspend, and 0 for a group finish, for an error and for code 0.
- R6: On each line, a lower group number wins. Within one group the finished event wins over the suspended event. Errors come below every group.
- R7: The line-select bit routes an event to line 0 (select 0) or line 1 (select 1). A source on one line never shows in the other line's vector.
- R8: A vector read strobe on a line clears the group flag that the line's vector names in that cycle, and the vector then shows the next source. A read while the vector shows an error, or shows 0, clears no flag.
- R9: An event pulse wins over a clear of the same flag in the same cycle. A flag set in the same cycle that a read clears another flag is kept.
- R10: A flag whose enable bit is 0 drives neither the line nor the vector, though it still reads back as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fin_evt_i | input | 16 | Group finished event pulses |
| sus_evt_i | input | 16 | Group suspended event pulses |
| err_evt_i | input | 4 | Error event pulses (bit, desync, parity, timeout) |
| fin_en_i | input | 16 | Enables for the finished flags |
| sus_en_i | input | 16 | Enables for the suspended flags |
| fin_sel_i | input | 16 | Line selects for the finished flags |
| sus_sel_i | input | 16 | Line selects for the suspended flags |
| err_en_i | input | 4 | Enables for the error flags |
| err_sel_i | input | 4 | Line selects for the error flags |
| flag_wr_i | input | 1 | Write-one-to-clear strobe |
| fin_w1c_i | input | 16 | Clear mask for the finished flags |
| sus_w1c_i | input | 16 | Clear mask for the suspended flags |
| err_w1c_i | input | 4 | Clear mask for the error flags |
| rd_ack_i | input | 2 | Vector read strobe, one bit per line |
| irq_o | output | 2 | Interrupt lines |
| vec0_o | output | 5 | Line 0 vector |
| sus0_o | output | 1 | Line 0 suspend type bit |
| vec1_o | output | 5 | Line 1 vector |
| sus1_o | output | 1 | Line 1 suspend type bit |
| fin_flag_o | output | 16 | Finished flags |
| sus_flag_o | output | 16 | Suspended flags |
| err_flag_o | output | 4 | Error flags |

## Verification
Directed steps place the following on the same line: a low and a high group, a disabled lower group, both events of one group, and a group alongside an error. These separate group-number order, finish-before-suspend order, group-before-error order and the masking by the enable bit. Further directed steps read the vector while it names a group, while it names an error, and in the same cycle that another flag is set. These separate clearing the named flag from clearing nothing, and show that a fresh set is not lost. Random phases with sparse events, random enables and line selects, and mixed write-clears and reads compare every flag, both lines and both vectors with a reference model each cycle. This exposes routing to the wrong line and any lost or spurious flag.

// File: rtl/irq_vec_pkg.sv
// Package: shared constants and the line identifier type for the interrupt
// vector unit. Assumes exactly two interrupt lines.
package irq_vec_pkg;
    localparam int NUM_LINES = 2;

    typedef enum logic {
        LINE_A = 1'b0,
        LINE_B = 1'b1
    } line_id_t;
endpackage

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// Holds a bank of sticky event flags. An event sets its flag. A masked
// write-one-to-clear or an acknowledge clear resets it. Assumes that set
// takes precedence over both clears in the same cycle.
module irq_flag_bank #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] w1c_i,
    input  logic [WIDTH-1:0] ack_clr_i,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] clr_mask;

    // Combine the software clear and the acknowledge clear into one mask.
    always_comb begin
        clr_mask = ack_clr_i | (wr_i ? w1c_i : '0);
    end

    // Update the flags: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= '0;
        end else begin
            flag_o <= (flag_o & ~clr_mask) | set_i;
        end
    end
endmodule

// File: rtl/irq_line_encoder.sv
// Module: irq_line_encoder
// Priority encoder for one interrupt line. It finds the lowest-numbered
// enabled group source mapped to this line, with finish ahead of suspend,
// and falls back to the shared error code. It also reports which flag the
// vector names, so that a read can clear that flag. Assumes that a select
// bit of 0 means line 0.
module irq_line_encoder #(
    parameter int NUM_GRP = 16,
    parameter int NUM_ERR = 4,
    parameter int LINE    = 0,
    parameter int VEC_W   = 5
) (
    input  logic [NUM_GRP-1:0] fin_flag_i,
    input  logic [NUM_GRP-1:0] sus_flag_i,
    input  logic [NUM_ERR-1:0] err_flag_i,
    input  logic [NUM_GRP-1:0] fin_en_i,
    input  logic [NUM_GRP-1:0] sus_en_i,
    input  logic [NUM_GRP-1:0] fin_sel_i,
    input  logic [NUM_GRP-1:0] sus_sel_i,
    input  logic [NUM_ERR-1:0] err_en_i,
    input  logic [NUM_ERR-1:0] err_sel_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               sus_o,
    output logic [NUM_GRP-1:0] hit_fin_o,
    output logic [NUM_GRP-1:0] hit_sus_o
);
    localparam logic [VEC_W-1:0] ERR_CODE = VEC_W'(NUM_GRP + 1);

    logic [NUM_GRP-1:0] fin_p;
    logic [NUM_GRP-1:0] sus_p;
    logic               err_any;

    // Keep only the enabled flags that are routed to this line.
    always_comb begin
        if (LINE != 0) begin
            fin_p   = fin_flag_i & fin_en_i & fin_sel_i;
            sus_p   = sus_flag_i & sus_en_i & sus_sel_i;
            err_any = |(err_flag_i & err_en_i & err_sel_i);
        end else begin
            fin_p   = fin_flag_i & fin_en_i & ~fin_sel_i;
            sus_p   = sus_flag_i & sus_en_i & ~sus_sel_i;
            err_any = |(err_flag_i & err_en_i & ~err_sel_i);
        end
    end

    // Pick the winner: scan from the lowest priority up, so later hits override.
    always_comb begin
        irq_o     = (|fin_p) | (|sus_p) | err_any;
        vec_o     = err_any ? ERR_CODE : '0;
        sus_o     = 1'b0;
        hit_fin_o = '0;
        hit_sus_o = '0;
        for (int g = NUM_GRP - 1; g >= 0; g--) begin
            if (sus_p[g]) begin
                vec_o        = VEC_W'(g + 1);
                sus_o        = 1'b1;
                hit_fin_o    = '0;
                hit_sus_o    = '0;
                hit_sus_o[g] = 1'b1;
            end
            if (fin_p[g]) begin
                vec_o        = VEC_W'(g + 1);
                sus_o        = 1'b0;
                hit_fin_o    = '0;
                hit_sus_o    = '0;
                hit_fin_o[g] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_vec_unit.sv
// Module: irq_vec_unit (top)
// Two-line prioritized interrupt vector unit. It latches group finish,
// group suspend and error events into flags, routes the enabled flags to
// two lines, and presents a vector and a type bit per line. A vector read
// clears the named group flag. Assumes that read and write strobes are
// single-cycle pulses from an external bus decoder.
module irq_vec_unit
    import irq_vec_pkg::*;
#(
    parameter  int NUM_GRP = 16,
    parameter  int NUM_ERR = 4,
    localparam int VEC_W   = $clog2(NUM_GRP + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] fin_evt_i,
    input  logic [NUM_GRP-1:0] sus_evt_i,
    input  logic [NUM_ERR-1:0] err_evt_i,
    input  logic [NUM_GRP-1:0] fin_en_i,
    input  logic [NUM_GRP-1:0] sus_en_i,
    input  logic [NUM_GRP-1:0] fin_sel_i,
    input  logic [NUM_GRP-1:0] sus_sel_i,
    input  logic [NUM_ERR-1:0] err_en_i,
    input  logic [NUM_ERR-1:0] err_sel_i,
    input  logic               flag_wr_i,
    input  logic [NUM_GRP-1:0] fin_w1c_i,
    input  logic [NUM_GRP-1:0] sus_w1c_i,
    input  logic [NUM_ERR-1:0] err_w1c_i,
    input  logic [1:0]         rd_ack_i,
    output logic [1:0]         irq_o,
    output logic [VEC_W-1:0]   vec0_o,
    output logic               sus0_o,
    output logic [VEC_W-1:0]   vec1_o,
    output logic               sus1_o,
    output logic [NUM_GRP-1:0] fin_flag_o,
    output logic [NUM_GRP-1:0] sus_flag_o,
    output logic [NUM_ERR-1:0] err_flag_o
);
    logic [VEC_W-1:0]   vec_w     [NUM_LINES];
    logic               sus_w     [NUM_LINES];
    logic [NUM_GRP-1:0] hit_fin_w [NUM_LINES];
    logic [NUM_GRP-1:0] hit_sus_w [NUM_LINES];
    logic [NUM_GRP-1:0] fin_ack;
    logic [NUM_GRP-1:0] sus_ack;

    irq_flag_bank #(.WIDTH(NUM_GRP)) u_fin_bank (
        .clk(clk), .rst_n(rst_n), .set_i(fin_evt_i), .wr_i(flag_wr_i),
        .w1c_i(fin_w1c_i), .ack_clr_i(fin_ack), .flag_o(fin_flag_o)
    );

    irq_flag_bank #(.WIDTH(NUM_GRP)) u_sus_bank (
        .clk(clk), .rst_n(rst_n), .set_i(sus_evt_i), .wr_i(flag_wr_i),
        .w1c_i(sus_w1c_i), .ack_clr_i(sus_ack), .flag_o(sus_flag_o)
    );

    irq_flag_bank #(.WIDTH(NUM_ERR)) u_err_bank (
        .clk(clk), .rst_n(rst_n), .set_i(err_evt_i), .wr_i(flag_wr_i),
        .w1c_i(err_w1c_i), .ack_clr_i('0), .flag_o(err_flag_o)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        irq_line_encoder #(
            .NUM_GRP(NUM_GRP), .NUM_ERR(NUM_ERR), .LINE(l), .VEC_W(VEC_W)
        ) u_enc (
            .fin_flag_i(fin_flag_o), .sus_flag_i(sus_flag_o), .err_flag_i(err_flag_o),
            .fin_en_i(fin_en_i), .sus_en_i(sus_en_i),
            .fin_sel_i(fin_sel_i), .sus_sel_i(sus_sel_i),
            .err_en_i(err_en_i), .err_sel_i(err_sel_i),
            .irq_o(irq_o[l]), .vec_o(vec_w[l]), .sus_o(sus_w[l]),
            .hit_fin_o(hit_fin_w[l]), .hit_sus_o(hit_sus_w[l])
        );
    end

    // Turn a vector read into a clear of the flag that the vector names.
    always_comb begin
        fin_ack = '0;
        sus_ack = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (rd_ack_i[l]) begin
                fin_ack = fin_ack | hit_fin_w[l];
                sus_ack = sus_ack | hit_sus_w[l];
            end
        end
    end

    // Drive the per-line output ports.
    always_comb begin
        vec0_o = vec_w[LINE_A];
        sus0_o = sus_w[LINE_A];
        vec1_o = vec_w[LINE_B];
        sus1_o = sus_w[LINE_B];
    end
endmodule

// File: rtl/irq_vec_checker.sv
// Module: irq_vec_checker
// Property checks on the ports of irq_vec_unit, attached through bind.
// Assumes a synchronous active-low reset.
module irq_vec_checker #(
    parameter  int NUM_GRP = 16,
    parameter  int NUM_ERR = 4,
    localparam int VEC_W   = $clog2(NUM_GRP + 2)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_GRP-1:0] fin_evt_i,
    input logic [NUM_GRP-1:0] sus_evt_i,
    input logic [NUM_ERR-1:0] err_evt_i,
    input logic [NUM_GRP-1:0] fin_en_i,
    input logic [NUM_GRP-1:0] sus_en_i,
    input logic [NUM_GRP-1:0] fin_sel_i,
    input logic [NUM_GRP-1:0] sus_sel_i,
    input logic [NUM_ERR-1:0] err_en_i,
    input logic [NUM_ERR-1:0] err_sel_i,
    input logic               flag_wr_i,
    input logic [NUM_GRP-1:0] fin_w1c_i,
    input logic [NUM_GRP-1:0] sus_w1c_i,
    input logic [NUM_ERR-1:0] err_w1c_i,
    input logic [1:0]         rd_ack_i,
    input logic [1:0]         irq_o,
    input logic [VEC_W-1:0]   vec0_o,
    input logic               sus0_o,
    input logic [VEC_W-1:0]   vec1_o,
    input logic               sus1_o,
    input logic [NUM_GRP-1:0] fin_flag_o,
    input logic [NUM_GRP-1:0] sus_flag_o,
    input logic [NUM_ERR-1:0] err_flag_o
);
    localparam logic [VEC_W-1:0] ERR_CODE = VEC_W'(NUM_GRP + 1);

    logic               was_run;
    logic [NUM_GRP-1:0] exp_fin_clr;
    logic [NUM_GRP-1:0] exp_sus_clr;

    // Mark the cycles after the first one out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) was_run <= 1'b0;
        else        was_run <= 1'b1;
    end

    // Decode from the vector ports which flags a read should clear.
    always_comb begin
        exp_fin_clr = '0;
        exp_sus_clr = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (rd_ack_i[0] && vec0_o == VEC_W'(g + 1)) begin
                if (sus0_o) exp_sus_clr[g] = 1'b1;
                else        exp_fin_clr[g] = 1'b1;
            end
            if (rd_ack_i[1] && vec1_o == VEC_W'(g + 1)) begin
                if (sus1_o) exp_sus_clr[g] = 1'b1;
                else        exp_fin_clr[g] = 1'b1;
            end
        end
    end

    // R2: every pulsed event is set one cycle later.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        was_run |=> ((fin_flag_o & $past(fin_evt_i)) == $past(fin_evt_i)) &&
                    ((sus_flag_o & $past(sus_evt_i)) == $past(sus_evt_i)) &&
                    ((err_flag_o & $past(err_evt_i)) == $past(err_evt_i)));

    // R3: a masked write clears the flags that saw no event.
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && flag_wr_i) |=>
            ((fin_flag_o & $past(fin_w1c_i & ~fin_evt_i)) == '0) &&
            ((err_flag_o & $past(err_w1c_i & ~err_evt_i)) == '0));

    // R4: an idle line has vector 0, and an active line has a non-zero vector.
    a_r4_line_vec0: assert property (@(posedge clk) disable iff (!rst_n)
        was_run |-> (irq_o[0] == (vec0_o != '0)) && (irq_o[1] == (vec1_o != '0)));

    // R5: the error code and code 0 never carry the suspend type.
    a_r5_err_no_sus: assert property (@(posedge clk) disable iff (!rst_n)
        was_run |-> !((vec0_o == ERR_CODE || vec0_o == '0) && sus0_o) &&
                    !((vec1_o == ERR_CODE || vec1_o == '0) && sus1_o));

    // R8: a read clears the group flag named by the vector.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && (|rd_ack_i)) |=>
            ((fin_flag_o & $past(exp_fin_clr & ~fin_evt_i)) == '0) &&
            ((sus_flag_o & $past(exp_sus_clr & ~sus_evt_i)) == '0));

    // R8: a read of an error vector leaves the error flags alone.
    a_r8_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (was_run && !flag_wr_i) |=> ((err_flag_o & $past(err_flag_o)) == $past(err_flag_o)));
endmodule

bind irq_vec_unit irq_vec_checker #(.NUM_GRP(NUM_GRP), .NUM_ERR(NUM_ERR)) u_chk (.*);

// File: tb/irq_vec_unit_bench.sv
// Bench for irq_vec_unit: directed corner cases, then seeded random
// stimulus, all compared against a reference model built from the
// requirements.
module irq_vec_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 16;
    localparam int NE = 4;
    localparam logic [4:0] ERRV = 5'd17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG-1:0] fin_evt = '0, sus_evt = '0, fin_en = '0, sus_en = '0;
    logic [NG-1:0] fin_sel = '0, sus_sel = '0, fin_w1c = '0, sus_w1c = '0;
    logic [NE-1:0] err_evt = '0, err_en = '0, err_sel = '0, err_w1c = '0;
    logic          flag_wr = 1'b0;
    logic [1:0]    rd_ack = 2'b00;
    logic [1:0]    irq;
    logic [4:0]    vec0, vec1;
    logic          sus0, sus1;
    logic [NG-1:0] fin_flag, sus_flag;
    logic [NE-1:0] err_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [NG-1:0] m_fin = '0, m_sus = '0;
    logic [NE-1:0] m_err = '0;

    irq_vec_unit u_irq_vec_unit (
        .clk(clk), .rst_n(rst_n),
        .fin_evt_i(fin_evt), .sus_evt_i(sus_evt), .err_evt_i(err_evt),
        .fin_en_i(fin_en), .sus_en_i(sus_en), .fin_sel_i(fin_sel), .sus_sel_i(sus_sel),
        .err_en_i(err_en), .err_sel_i(err_sel), .flag_wr_i(flag_wr),
        .fin_w1c_i(fin_w1c), .sus_w1c_i(sus_w1c), .err_w1c_i(err_w1c),
        .rd_ack_i(rd_ack), .irq_o(irq), .vec0_o(vec0), .sus0_o(sus0),
        .vec1_o(vec1), .sus1_o(sus1), .fin_flag_o(fin_flag), .sus_flag_o(sus_flag),
        .err_flag_o(err_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference vector for one line: R4, R5, R6, R7, R10.
    function automatic void model_line(input int ln, output logic [4:0] v,
                                       output logic s, output logic q);
        bit found = 0;
        v = '0; s = 1'b0; q = 1'b0;
        for (int g = 0; g < NG; g++) begin
            if (m_fin[g] && fin_en[g] && (int'(fin_sel[g]) == ln)) begin
                q = 1'b1;
                if (!found) begin v = 5'(g + 1); s = 1'b0; found = 1; end
            end
            if (m_sus[g] && sus_en[g] && (int'(sus_sel[g]) == ln)) begin
                q = 1'b1;
                if (!found) begin v = 5'(g + 1); s = 1'b1; found = 1; end
            end
        end
        for (int e = 0; e < NE; e++) begin
            if (m_err[e] && err_en[e] && (int'(err_sel[e]) == ln)) begin
                q = 1'b1;
                if (!found) begin v = ERRV; found = 1; end
            end
        end
    endfunction

    // Reference flag update: R2, R3, R8, R9.
    always @(posedge clk) begin
        logic [4:0] v; logic s, q;
        logic [NG-1:0] fa, sa;
        fa = '0; sa = '0;
        if (!rst_n) begin
            m_fin <= '0; m_sus <= '0; m_err <= '0;
        end else begin
            for (int l = 0; l < 2; l++) begin
                model_line(l, v, s, q);
                if (rd_ack[l] && v != 0 && v != ERRV) begin
                    if (s) sa[v - 1] = 1'b1;
                    else   fa[v - 1] = 1'b1;
                end
            end
            m_fin <= (m_fin & ~fa & ~(flag_wr ? fin_w1c : '0)) | fin_evt;
            m_sus <= (m_sus & ~sa & ~(flag_wr ? sus_w1c : '0)) | sus_evt;
            m_err <= (m_err & ~(flag_wr ? err_w1c : '0)) | err_evt;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic check_all(input string req);
        logic [4:0] v0, v1; logic s0, s1, q0, q1;
        model_line(0, v0, s0, q0);
        model_line(1, v1, s1, q1);
        chk(req, "fin_flag", 32'(fin_flag), 32'(m_fin));
        chk(req, "sus_flag", 32'(sus_flag), 32'(m_sus));
        chk(req, "err_flag", 32'(err_flag), 32'(m_err));
        chk(req, "irq", 32'(irq), 32'({q1, q0}));
        chk(req, "vec0", 32'({sus0, vec0}), 32'({s0, v0}));
        chk(req, "vec1", 32'({sus1, vec1}), 32'({s1, v1}));
    endtask

    // Advance one cycle, drop the pulses, compare at the falling edge.
    task automatic step(input string req);
        @(posedge clk);
        @(negedge clk);
        fin_evt = '0; sus_evt = '0; err_evt = '0;
        flag_wr = 1'b0; fin_w1c = '0; sus_w1c = '0; err_w1c = '0; rd_ack = 2'b00;
        check_all(req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "flags", 32'({fin_flag, sus_flag, err_flag}), 32'd0);
        chk("R1", "irq", 32'(irq), 32'd0);
        chk("R1", "vecs", 32'({vec1, vec0}), 32'd0);

        // R6 / R10: group 3 finish and group 5 suspend on line 0; group 1 disabled
        fin_en[3] = 1; sus_en[5] = 1;
        fin_evt[3] = 1; sus_evt[5] = 1; fin_evt[1] = 1;
        step("R6");
        chk("R6", "vec0", 32'({sus0, vec0}), 32'({1'b0, 5'd4}));
        chk("R10", "disabled flag set, no vector", 32'({fin_flag[1], irq[1]}), 32'b10);
        chk("R2", "fin_flag1", 32'(fin_flag[1]), 32'd1);
        chk("R4", "irq0", 32'(irq[0]), 32'd1);

        // R8: reading line 0 clears group 3 finish and advances to group 5 suspend
        rd_ack[0] = 1;
        step("R8");
        chk("R8", "vec0 next", 32'({sus0, vec0}), 32'({1'b1, 5'd6}));
        chk("R8", "fin_flag3", 32'(fin_flag[3]), 32'd0);

        // R9: a read clears group 5 while group 9 sets in the same cycle
        fin_en[9] = 1; fin_evt[9] = 1; rd_ack[0] = 1;
        step("R9");
        chk("R9", "vec0 new", 32'({sus0, vec0}), 32'({1'b0, 5'd10}));
        chk("R9", "sus_flag5", 32'(sus_flag[5]), 32'd0);

        // R6 / R7: both events of group 2 on line 1
        fin_en[2] = 1; sus_en[2] = 1; fin_sel[2] = 1; sus_sel[2] = 1;
        fin_evt[2] = 1; sus_evt[2] = 1;
        step("R6");
        chk("R6", "fin before sus", 32'({sus1, vec1}), 32'({1'b0, 5'd3}));
        chk("R7", "line0 untouched", 32'(vec0), 32'd10);
        rd_ack[1] = 1;
        step("R8");
        chk("R8", "sus after fin", 32'({sus1, vec1}), 32'({1'b1, 5'd3}));
        rd_ack[1] = 1;
        step("R8");
        chk("R8", "line1 empty", 32'({irq[1], vec1}), 32'd0);

        // R5 / R6: error and group 12 on line 1
        err_en[1] = 1; err_sel[1] = 1; fin_en[12] = 1; fin_sel[12] = 1;
        err_evt[1] = 1; fin_evt[12] = 1;
        step("R6");
        chk("R6", "group over error", 32'(vec1), 32'd13);
        rd_ack[1] = 1;
        step("R5");
        chk("R5", "error code", 32'({sus1, vec1}), 32'({1'b0, ERRV}));
        rd_ack[1] = 1;
        step("R8");
        chk("R8", "error read keeps flag", 32'({err_flag[1], vec1}), 32'({1'b1, ERRV}));

        // R3: zero mask keeps, one mask clears
        flag_wr = 1;
        step("R3");
        chk("R3", "zero mask", 32'({err_flag[1], fin_flag[1]}), 32'b11);
        flag_wr = 1; err_w1c[1] = 1;
        step("R3");
        chk("R3", "err cleared", 32'({err_flag[1], vec1}), 32'd0);

        // R9: set wins over write-clear of the same flag
        flag_wr = 1; fin_w1c[1] = 1; fin_evt[1] = 1;
        step("R9");
        chk("R9", "set wins", 32'(fin_flag[1]), 32'd1);
        flag_wr = 1; fin_w1c[1] = 1;
        step("R3");
        chk("R3", "cleared", 32'(fin_flag[1]), 32'd0);

        // R2 R4 R5 R6 R7 R8: random phase against the model
        for (int i = 0; i < 3000; i++) begin
            if (i % 64 == 0) begin
                fin_en = 16'($urandom); sus_en = 16'($urandom);
                fin_sel = 16'($urandom); sus_sel = 16'($urandom);
                err_en = 4'($urandom); err_sel = 4'($urandom);
            end
            fin_evt = 16'($urandom & $urandom & $urandom & $urandom);
            sus_evt = 16'($urandom & $urandom & $urandom & $urandom);
            err_evt = 4'($urandom & $urandom & $urandom);
            flag_wr = ($urandom % 4) == 0;
            fin_w1c = 16'($urandom & $urandom);
            sus_w1c = 16'($urandom & $urandom);
            err_w1c = 4'($urandom);
            rd_ack = 2'($urandom & $urandom);
            step("R8");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule